// File: doc/BRIEF.md
# Pin-Configured Conversion Sequencing Controller

This controller schedules conversions for a converter whose setup comes only from static pins. The pins are an output-rate code, a gain code, a channel select, a temperature-sensor select, a clock-source select and a power-down input that also acts as a reset. The modulator and the digital filter are not modelled. A counter of master-clock cycles stands in for one conversion period, and the controller decides when the filter must be cleared and when a conversion result is ready.

Every configuration pin passes through a two-stage synchroniser before a change on it is detected. A change on any of them clears the filter with a one-cycle `filt_rst_o` pulse and raises the not-ready flag. Conversions then restart under the new setup: the first result arrives after four conversion periods and later results follow one period apart.

A power-down request counts only if the pin is held for a minimum number of cycles. While it is held, the block stays idle with its active configuration cleared. On release, the block waits for the on-chip oscillator if the internal clock source is selected, and does not wait with an external source. The power-up reset behaves like a release from power-down. The outputs feed a separate serial readout block.

Top module: `conv_seq_ctrl`

## Requirements
- R1: The rate code decodes to `rate_hz_o` as 2'b11 = 10, 2'b10 = 50, 2'b01 = 60 and 2'b00 = 120. The conversion period is P = BASE_CYC*120/rate cycles.
- R2: The gain code decodes to `gain_o` as 2'b00 = 1, 2'b01 = 8, 2'b10 = 64 and 2'b11 = 128.
- R3: `src_o` reads 0 for input pair 1 when the channel select is low and 1 for input pair 2 when it is high. When the temperature select is high, `src_o` reads 2 whatever the channel select is.
- R4: A change on any configuration pin (rate, gain, channel, temperature or clock source) while converting gives a one-cycle `filt_rst_o` pulse and drives `ready_n_o` high. Any settling already in progress is abandoned.
- R5: The first `conv_done_o` comes exactly 4*P cycles after the `filt_rst_o` cycle. Later pulses come exactly P cycles apart, and each pulse lasts one cycle.
- R6: When `pdown_i` is held high for at least PDN_MIN_CYC synchronised cycles, the block is idle. In that state `sleep_o` = 1, `ready_n_o` = 1, no `conv_done_o` occurs, and `rate_hz_o` and `gain_o` read 0.
- R7: A `pdown_i` pulse shorter than PDN_MIN_CYC cycles has no effect: there is no restart, no sleep, and the conversion cadence continues.
- R8: On release from power-down with the internal clock selected, the restart comes exactly WAKE_CYC cycles later than it does with an external clock.
- R9: While `rst_n` is low, `sleep_o` = 1, `ready_n_o` = 1 and there are no pulses. After reset, a restart follows and conversions begin.
- R10: `ready_n_o` falls only in the cycle after a `conv_done_o` that ends settling, and stays low until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Power-up reset, active low |
| rate_sel_i | input | 2 | Output-rate code pins |
| gain_sel_i | input | 2 | Gain code pins |
| chan_sel_i | input | 1 | Input pair select |
| temp_sel_i | input | 1 | Temperature-sensor select |
| int_clk_sel_i | input | 1 | High selects the internal oscillator |
| pdown_i | input | 1 | Power-down / reset request |
| conv_done_o | output | 1 | One-cycle conversion-complete strobe |
| filt_rst_o | output | 1 | One-cycle filter-clear pulse |
| ready_n_o | output | 1 | High while settling, asleep or in reset |
| sleep_o | output | 1 | High while powered down or waking |
| rate_hz_o | output | 7 | Active output rate in Hz |
| gain_o | output | 8 | Active gain |
| src_o | output | 2 | Active source (0 pair 1, 1 pair 2, 2 temperature) |

## Verification
The hardest situation to reach from the ports is the wake-up wait itself. The synchroniser and qualifier latency comes before it and is never visible, so the bench cannot time the wait directly. Instead, the bench releases power-down twice, once with each clock source, and compares the two release-to-restart latencies; the fixed pipeline delay cancels out. The bench also changes a pin inside a settling window, to show that the old window is dropped. It sends a power-down pulse just under the qualifying length between two strobes, to show that the cadence does not move.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int CFG_W = 7;  // [1:0] rate, [3:2] gain, [4] chan, [5] temp, [6] clk src

  typedef enum logic [1:0] {
    SRC_PAIR1 = 2'd0,
    SRC_PAIR2 = 2'd1,
    SRC_TEMP  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAKE,
    ST_SETTLE,
    ST_RUN
  } seq_st_e;

  function automatic logic [6:0] rate_hz(input logic [1:0] code);
    case (code)
      2'b11:   return 7'd10;
      2'b10:   return 7'd50;
      2'b01:   return 7'd60;
      default: return 7'd120;
    endcase
  endfunction

  function automatic logic [7:0] gain_of(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd1;
      2'b01:   return 8'd8;
      2'b10:   return 8'd64;
      default: return 8'd128;
    endcase
  endfunction

  function automatic src_e src_of(input logic chan, input logic temp);
    if (temp) return SRC_TEMP;
    return chan ? SRC_PAIR2 : SRC_PAIR1;
  endfunction

  // BASE_CYC is the 120 Hz period; keep it a multiple of 5 so 50 Hz is exact
  function automatic int unsigned period_cyc(input logic [1:0] code, input int unsigned base);
    return (base * 120) / int'(rate_hz(code));
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         changed,
  output logic         primed
);
  localparam int PW = $clog2(STAGES + 2);

  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;
  logic [PW-1:0]            pcnt;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= din;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      pcnt <= '0;
    end else begin
      prev <= stg[STAGES-1];
      if (pcnt != PW'(STAGES + 1)) pcnt <= pcnt + 1'b1;
    end
  end

  assign dout    = stg[STAGES-1];
  assign primed  = (pcnt == PW'(STAGES + 1));
  assign changed = primed && (prev != stg[STAGES-1]);

endmodule

// File: rtl/pdn_qual.sv
module pdn_qual #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_raw,
  output logic pd_active
);
  localparam int QW = $clog2(MIN_CYC + 1);

  logic [1:0]    sync_q;
  logic          pd_s;
  logic [QW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      hold_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], pd_raw};
      if (!pd_s)                          hold_cnt <= '0;
      else if (hold_cnt != QW'(MIN_CYC))  hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign pd_s      = sync_q[1];
  assign pd_active = (hold_cnt == QW'(MIN_CYC));

  // a qualified request only appears after the synchronised pin was high
  assert_hold_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> $past(pd_s));

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period,
  output logic             done,
  output logic             settling
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      lim      <= '0;
      active   <= 1'b0;
      settling <= 1'b0;
    end else if (restart) begin
      cnt      <= '0;
      lim      <= period << 2;
      active   <= 1'b1;
      settling <= 1'b1;
    end else if (!run_en) begin
      cnt      <= '0;
      lim      <= '0;
      active   <= 1'b0;
      settling <= 1'b0;
    end else if (active) begin
      if (cnt == lim) begin
        cnt      <= CNT_W'(1);
        lim      <= period;
        settling <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done = active && (cnt == lim);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_settle_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && settling && !restart && run_en) |=> !settling);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int BASE_CYC    = 41000,
  parameter int WAKE_CYC    = 4920,
  parameter int PDN_MIN_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel_i,
  input  logic [1:0] gain_sel_i,
  input  logic       chan_sel_i,
  input  logic       temp_sel_i,
  input  logic       int_clk_sel_i,
  input  logic       pdown_i,
  output logic       conv_done_o,
  output logic       filt_rst_o,
  output logic       ready_n_o,
  output logic       sleep_o,
  output logic [6:0] rate_hz_o,
  output logic [7:0] gain_o,
  output logic [1:0] src_o
);
  localparam int CNT_W = $clog2(4 * BASE_CYC * 12 + 1);
  localparam int WW    = $clog2(WAKE_CYC + 1);

  logic [CFG_W-1:0] cfg_s;
  logic             cfg_changed, cfg_primed;
  logic             pd_active;
  logic             tmr_done, tmr_settling;
  logic [CNT_W-1:0] period_w;

  seq_st_e          state, state_nx;
  logic [WW-1:0]    wcnt;
  logic             wake_go, restart, converting;
  logic             filt_rst_q;
  logic [6:0]       rate_q;
  logic [7:0]       gain_q;
  src_e             src_q;

  cfg_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     ({int_clk_sel_i, temp_sel_i, chan_sel_i, gain_sel_i, rate_sel_i}),
    .dout    (cfg_s),
    .changed (cfg_changed),
    .primed  (cfg_primed)
  );

  pdn_qual #(.MIN_CYC(PDN_MIN_CYC)) u_pdn (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_raw    (pdown_i),
    .pd_active (pd_active)
  );

  assign period_w   = CNT_W'(period_cyc(cfg_s[1:0], BASE_CYC));
  assign converting = (state == ST_SETTLE) || (state == ST_RUN);
  assign wake_go    = (state == ST_WAKE) && cfg_primed &&
                      (!cfg_s[6] || (wcnt >= WW'(WAKE_CYC)));
  assign restart    = !pd_active && (wake_go || (converting && cfg_changed));

  conv_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .run_en   (converting),
    .period   (period_w),
    .done     (tmr_done),
    .settling (tmr_settling)
  );

  always_comb begin
    state_nx = state;
    if (pd_active) state_nx = ST_OFF;
    else begin
      case (state)
        ST_OFF:    state_nx = ST_WAKE;
        ST_WAKE:   if (wake_go) state_nx = ST_SETTLE;
        ST_SETTLE: if (restart) state_nx = ST_SETTLE;
                   else if (tmr_done && tmr_settling) state_nx = ST_RUN;
        ST_RUN:    if (restart) state_nx = ST_SETTLE;
        default:   state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WAKE;
      wcnt       <= '0;
      filt_rst_q <= 1'b0;
      rate_q     <= '0;
      gain_q     <= '0;
      src_q      <= SRC_PAIR1;
    end else begin
      state      <= state_nx;
      filt_rst_q <= restart;
      if (state == ST_WAKE) begin
        if (wcnt != WW'(WAKE_CYC)) wcnt <= wcnt + 1'b1;
      end else begin
        wcnt <= '0;
      end
      if (pd_active) begin
        rate_q <= '0;
        gain_q <= '0;
        src_q  <= SRC_PAIR1;
      end else if (restart) begin
        rate_q <= rate_hz(cfg_s[1:0]);
        gain_q <= gain_of(cfg_s[3:2]);
        src_q  <= src_of(cfg_s[4], cfg_s[5]);
      end
    end
  end

  assign conv_done_o = tmr_done && converting && !pd_active;
  assign filt_rst_o  = filt_rst_q;
  assign ready_n_o   = (state != ST_RUN);
  assign sleep_o     = (state == ST_OFF) || (state == ST_WAKE);
  assign rate_hz_o   = rate_q;
  assign gain_o      = gain_q;
  assign src_o       = src_q;

  assert_restart_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst_o |-> (ready_n_o && !conv_done_o));
  assert_pd_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> (sleep_o && !conv_done_o && ready_n_o));
  assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n_o) |-> $past(conv_done_o));
  assert_gain_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_o |-> ($countones(gain_o) == 1));
  assert_no_done_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !conv_done_o);

endmodule

// File: tb/conv_seq_ctrl_tb.sv
module conv_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 20;
  localparam int WAKE       = 50;
  localparam int PDMIN      = 4;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel_i = 2'b00;
  logic [1:0] gain_sel_i = 2'b00;
  logic       chan_sel_i = 1'b0;
  logic       temp_sel_i = 1'b0;
  logic       int_clk_sel_i = 1'b0;
  logic       pdown_i = 1'b0;
  logic       conv_done_o, filt_rst_o, ready_n_o, sleep_o;
  logic [6:0] rate_hz_o;
  logic [7:0] gain_o;
  logic [1:0] src_o;

  int checks = 0, fails = 0;
  int cyc = 0;
  int n_rst = 0, n_done = 0, n_sleep = 0;
  int t_rst = 0, t_done = 0, t_prev = 0;

  conv_seq_ctrl #(.BASE_CYC(BASE), .WAKE_CYC(WAKE), .PDN_MIN_CYC(PDMIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i), .gain_sel_i(gain_sel_i),
    .chan_sel_i(chan_sel_i), .temp_sel_i(temp_sel_i), .int_clk_sel_i(int_clk_sel_i),
    .pdown_i(pdown_i), .conv_done_o(conv_done_o), .filt_rst_o(filt_rst_o),
    .ready_n_o(ready_n_o), .sleep_o(sleep_o), .rate_hz_o(rate_hz_o),
    .gain_o(gain_o), .src_o(src_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected below %0d)", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (filt_rst_o)  begin n_rst++; t_rst = cyc; end
    if (conv_done_o) begin n_done++; t_prev = t_done; t_done = cyc; end
    if (sleep_o && rst_n) n_sleep++;
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int exp_hz(input logic [1:0] c);
    int t[4] = '{120, 60, 50, 10};
    return t[c];
  endfunction

  function automatic int exp_p(input logic [1:0] c);
    return BASE * 120 / exp_hz(c);
  endfunction

  task automatic wait_rst();
    int base = n_rst;
    for (int k = 0; k < 4000 && n_rst == base; k++) begin @(negedge clk); #1; end
    if (n_rst == base) check(0, "timeout waiting for filt_rst", 0, 1);
  endtask

  task automatic wait_done();
    int base = n_done;
    for (int k = 0; k < 4000 && n_done == base; k++) begin @(negedge clk); #1; end
    if (n_done == base) check(0, "timeout waiting for conv_done", 0, 1);
  endtask

  // restart seen, then first result at 4P, next at P, ready low after
  task automatic measure_conv(input int p, input string tag);
    int r;
    wait_rst();
    r = t_rst;
    check(ready_n_o == 1'b1, {tag, " R4 ready_n high after restart"}, ready_n_o, 1);
    wait_done();
    check(t_done - r == 4 * p, {tag, " R5 first result delay"}, t_done - r, 4 * p);
    wait_done();
    check(t_done - t_prev == p, {tag, " R5 result spacing"}, t_done - t_prev, p);
    @(negedge clk); #1;
    check(ready_n_o == 1'b0, {tag, " R10 ready_n low once settled"}, ready_n_o, 0);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    #1;
    check(sleep_o == 1'b1 && ready_n_o == 1'b1, "R9 idle during reset",
          {sleep_o, ready_n_o}, 2'b11);
    check(conv_done_o == 1'b0 && filt_rst_o == 1'b0, "R9 no pulses in reset",
          {conv_done_o, filt_rst_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    measure_conv(exp_p(2'b00), "reset");
    check(rate_hz_o == 7'd120, "R1 rate after reset", rate_hz_o, 120);
  endtask

  task automatic t_rates();
    logic [1:0] codes[4] = '{2'b11, 2'b10, 2'b01, 2'b00};
    foreach (codes[i]) begin
      @(negedge clk) rate_sel_i = codes[i];
      measure_conv(exp_p(codes[i]), "rate");
      check(rate_hz_o == 7'(exp_hz(codes[i])), "R1 rate decode", rate_hz_o, exp_hz(codes[i]));
    end
  endtask

  task automatic t_gains();
    logic [1:0] codes[4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    int exp_g[4] = '{8, 64, 128, 1};
    foreach (codes[i]) begin
      @(negedge clk) gain_sel_i = codes[i];
      measure_conv(exp_p(2'b00), "gain");
      check(gain_o == 8'(exp_g[i]), "R2 gain decode", gain_o, exp_g[i]);
    end
  endtask

  task automatic t_sources();
    @(negedge clk) chan_sel_i = 1'b1;
    wait_rst(); @(negedge clk); #1;
    check(src_o == 2'd1, "R3 pair 2 selected", src_o, 1);
    @(negedge clk) temp_sel_i = 1'b1;
    wait_rst(); @(negedge clk); #1;
    check(src_o == 2'd2, "R3 temperature overrides chan high", src_o, 2);
    @(negedge clk) chan_sel_i = 1'b0;
    wait_rst(); @(negedge clk); #1;
    check(src_o == 2'd2, "R3 temperature overrides chan low", src_o, 2);
    @(negedge clk) temp_sel_i = 1'b0;
    measure_conv(exp_p(2'b00), "source");
    check(src_o == 2'd0, "R3 pair 1 selected", src_o, 0);
  endtask

  task automatic t_mid_settle();
    int nd, r1;
    @(negedge clk) gain_sel_i = 2'b01;
    wait_rst();
    r1 = t_rst;
    nd = n_done;
    repeat (30) @(negedge clk);
    gain_sel_i = 2'b10;
    wait_rst();
    check(t_rst - r1 < 4 * exp_p(2'b00), "R4 second restart inside settle window",
          t_rst - r1, 4 * exp_p(2'b00));
    check(n_done == nd, "R4 abandoned settle gives no result", n_done - nd, 0);
    wait_done();
    check(t_done - t_rst == 4 * exp_p(2'b00), "R4 settle restarted from new edge",
          t_done - t_rst, 4 * exp_p(2'b00));
    check(gain_o == 8'd64, "R2 gain after mid-settle change", gain_o, 64);
  endtask

  task automatic t_clksel();
    int nr = n_rst;
    @(negedge clk) int_clk_sel_i = 1'b1;
    measure_conv(exp_p(2'b00), "clksel on");
    check(n_rst == nr + 1, "R4 clock-source edge restarts", n_rst - nr, 1);
    @(negedge clk) int_clk_sel_i = 1'b0;
    measure_conv(exp_p(2'b00), "clksel off");
  endtask

  task automatic t_short_pd();
    int nr, ns;
    wait_done();
    nr = n_rst; ns = n_sleep;
    @(negedge clk) pdown_i = 1'b1;
    repeat (2) @(negedge clk);
    pdown_i = 1'b0;
    wait_done();
    check(t_done - t_prev == exp_p(2'b00), "R7 cadence unchanged by short pulse",
          t_done - t_prev, exp_p(2'b00));
    check(n_rst == nr, "R7 no restart from short pulse", n_rst - nr, 0);
    check(n_sleep == ns, "R7 no sleep from short pulse", n_sleep - ns, 0);
    check(ready_n_o == 1'b0, "R7 still ready after short pulse", ready_n_o, 0);
  endtask

  task automatic t_long_pd();
    int nd, tf, le, li;
    @(negedge clk) pdown_i = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check(sleep_o == 1'b1 && ready_n_o == 1'b1, "R6 asleep and not ready",
          {sleep_o, ready_n_o}, 2'b11);
    check(gain_o == 8'd0 && rate_hz_o == 7'd0, "R6 active config cleared",
          {gain_o, rate_hz_o}, 0);
    nd = n_done;
    repeat (300) @(negedge clk);
    check(n_done == nd, "R6 no results while powered down", n_done - nd, 0);
    pdown_i = 1'b0; tf = cyc;
    wait_rst(); le = t_rst - tf;
    @(negedge clk) pdown_i = 1'b1;
    repeat (10) @(negedge clk);
    int_clk_sel_i = 1'b1;
    repeat (10) @(negedge clk);
    pdown_i = 1'b0; tf = cyc;
    wait_rst(); li = t_rst - tf;
    check(li - le == WAKE, "R8 oscillator wait with internal clock", li - le, WAKE);
    wait_done();
    check(t_done - t_rst == 4 * exp_p(2'b00), "R5 first result after wake",
          t_done - t_rst, 4 * exp_p(2'b00));
  endtask

  initial begin
    t_reset();
    t_rates();
    t_gains();
    t_sources();
    t_mid_settle();
    t_clksel();
    t_short_pd();
    t_long_pd();
    summary();
    $finish;
  end

endmodule